// File: doc/BRIEF.md
# Soft-Commutation Half-Bridge Sequencer

This block steps one leg's series-switch half-bridge from one position to the other with zero-voltage transitions only. When a commutation is requested, it suspends the leg's PWM and current control. It then forces a fixed number of full-bridge modules to one polarity, so that the leg current ramps linearly through zero. The outgoing switch is turned off only once the current has moved into that switch's anti-parallel diode. The module polarity is then reversed, so that the current swings back across zero and carries the switch node to the opposite rail. The incoming switch is gated only after the node voltage has reached that rail.

The surrounding controller supplies four things: the request and its direction, the sampled leg current, the sampled switch-node voltage together with the input-rail voltage, and the number of modules to force. The block drives the two gate enables, the PWM/current-control enable, and a thermometer mask of forced modules with a polarity bit. It also raises one-cycle done and fault pulses. Each waiting phase has a timeout. A timeout before the diode path exists keeps the original switch on. A timeout after the diode path exists parks the leg with both gates off.

Top module: `hb_soft_commutator`

## Requirements
- R1: After reset the upper gate is on and the lower gate is off. The PWM enable is high, the force mask is zero, and done and fault are low.
- R2: The upper and lower gate enables are never high in the same cycle.
- R3: Input encodings: `dir`=0 requests upper-to-lower and `dir`=1 requests lower-to-upper. `force_pos`=1 means the forced modules raise the leg current. A request is accepted when the leg sits at the source position and the current has the source sign: positive for `dir`=0, negative for `dir`=1. In the cycle after an accepted request, `pwm_en` is low. `force_mask` then has its lowest min(`force_cnt`, N_MOD) bits set, using the count captured with the request. `force_pos` equals `dir`, so the current is driven toward zero.
- R4: A request with the wrong position or the wrong current sign leaves the gates and `pwm_en` unchanged and produces a one-cycle `fault` pulse.
- R5: The outgoing gate stays on until the current has crossed zero. In the cycle after the crossing, both gates are off and `force_pos` is inverted.
- R6: The incoming gate turns on only after two conditions hold together. The current must be back past zero. The node must be at the target rail: `v_node` ≤ V_TOL going down, or `v_node` + V_TOL ≥ `v_top` going up. The incoming gate is then on for one cycle with `pwm_en` still low. After that, `pwm_en` returns high and `done` pulses for one cycle.
- R7: While the outgoing gate conducts, the node must stay at the source rail. If it leaves that rail, `fault` pulses and the sequence aborts to idle with the original gate on and `pwm_en` high.
- R8: If the current does not cross zero within TMO_CYC cycles, `fault` pulses and the leg returns to idle on its original gate with `pwm_en` high.
- R9: If the incoming phase times out, `fault` pulses and the leg returns to idle with both gates off and `pwm_en` high. Every later request is rejected with a `fault` pulse until reset.
- R10: A request that arrives while a sequence is running has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Commutation request, sampled in idle |
| dir | input | 1 | 0 upper-to-lower, 1 lower-to-upper |
| i_leg | input | CUR_W | Signed sampled leg current |
| v_node | input | VOLT_W | Sampled switch-node voltage |
| v_top | input | VOLT_W | Sampled input-rail voltage |
| force_cnt | input | CNT_W | Number of modules to force |
| gate_hi | output | 1 | Upper switch gate enable |
| gate_lo | output | 1 | Lower switch gate enable |
| pwm_en | output | 1 | PWM and current-control enable |
| force_mask | output | N_MOD | Thermometer mask of forced modules |
| force_pos | output | 1 | Forced polarity, 1 raises leg current |
| done | output | 1 | One-cycle pulse at completion |
| fault | output | 1 | One-cycle pulse on rejection, abort or timeout |

## Verification
The bench builds the block with N_MOD=4, CNT_W=3, V_TOL=10 and TMO_CYC=16. With these values, a count of 6 shows mask saturation and a count of 2 shows a partial mask. A 16-cycle timeout lets both the outgoing-phase and incoming-phase expiries be reached within a few dozen cycles. The 10-count tolerance puts node values such as 795 and 3 inside the rail windows and 500 clearly outside them. The mirrored lower-to-upper path is exercised with the opposite current signs.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OUT    = 2'd1,
        ST_IN     = 2'd2,
        ST_ENGAGE = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic i_pos;
        logic i_neg;
        logic v_low;
        logic v_high;
    } sense_t;

    function automatic logic is_wait(input seq_state_t s);
        return (s == ST_OUT) || (s == ST_IN);
    endfunction

endpackage

// File: rtl/hbc_sense.sv
module hbc_sense
    import hbc_pkg::*;
#(
    parameter int CUR_W  = 12,
    parameter int VOLT_W = 12,
    parameter int V_TOL  = 10
) (
    input  logic signed [CUR_W-1:0] i_leg,
    input  logic [VOLT_W-1:0]       v_node,
    input  logic [VOLT_W-1:0]       v_top,
    output sense_t                  flags
);
    localparam logic [VOLT_W:0] TOL = (VOLT_W+1)'(V_TOL);

    logic [VOLT_W:0] node_ext, top_ext;

    always_comb begin
        node_ext     = {1'b0, v_node};
        top_ext      = {1'b0, v_top};
        flags.i_pos  = (i_leg > 0);
        flags.i_neg  = i_leg[CUR_W-1];
        flags.v_low  = (node_ext <= TOL);
        flags.v_high = ((node_ext + TOL) >= top_ext);
    end
endmodule

// File: rtl/hbc_timeout.sv
module hbc_timeout #(
    parameter int TMO_CYC = 16,
    parameter int PH_W    = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PH_W-1:0] phase,
    output logic            expired
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(TMO_CYC - 1);

    logic [CW-1:0]   cnt;
    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            phase_q <= '0;
        end else begin
            phase_q <= phase;
            if (!run || phase != phase_q)
                cnt <= '0;
            else if (cnt != LIM)
                cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (phase == phase_q) && (cnt == LIM);
endmodule

// File: rtl/hbc_force_pattern.sv
module hbc_force_pattern #(
    parameter int N_MOD = 4,
    parameter int CNT_W = 3
) (
    input  logic             active,
    input  logic [CNT_W-1:0] count,
    output logic [N_MOD-1:0] mask
);
    for (genvar k = 0; k < N_MOD; k++) begin : g_bit
        assign mask[k] = active && (32'(count) > k);
    end
endmodule

// File: rtl/hb_soft_commutator.sv
module hb_soft_commutator
    import hbc_pkg::*;
#(
    parameter int CUR_W   = 12,
    parameter int VOLT_W  = 12,
    parameter int N_MOD   = 4,
    parameter int CNT_W   = 3,
    parameter int V_TOL   = 10,
    parameter int TMO_CYC = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req,
    input  logic                    dir,
    input  logic signed [CUR_W-1:0] i_leg,
    input  logic [VOLT_W-1:0]       v_node,
    input  logic [VOLT_W-1:0]       v_top,
    input  logic [CNT_W-1:0]        force_cnt,
    output logic                    gate_hi,
    output logic                    gate_lo,
    output logic                    pwm_en,
    output logic [N_MOD-1:0]        force_mask,
    output logic                    force_pos,
    output logic                    done,
    output logic                    fault
);
    seq_state_t       state, st_d;
    logic             pos_hi, pos_d;
    logic             parked, parked_d;
    logic             dir_q, dir_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_d, fault_d;
    logic             expired;
    sense_t           sns;

    hbc_sense #(.CUR_W(CUR_W), .VOLT_W(VOLT_W), .V_TOL(V_TOL)) u_sense (
        .i_leg(i_leg), .v_node(v_node), .v_top(v_top), .flags(sns)
    );

    hbc_timeout #(.TMO_CYC(TMO_CYC), .PH_W(2)) u_tmo (
        .clk(clk), .rst(rst), .run(is_wait(state)),
        .phase(state), .expired(expired)
    );

    hbc_force_pattern #(.N_MOD(N_MOD), .CNT_W(CNT_W)) u_pat (
        .active(is_wait(state)), .count(cnt_q), .mask(force_mask)
    );

    always_comb begin
        st_d     = state;
        pos_d    = pos_hi;
        parked_d = parked;
        dir_d    = dir_q;
        cnt_d    = cnt_q;
        done_d   = 1'b0;
        fault_d  = 1'b0;
        unique case (state)
            ST_IDLE: if (req) begin
                if (!parked && (dir ? !pos_hi : pos_hi) && (dir ? sns.i_neg : sns.i_pos)) begin
                    st_d  = ST_OUT;
                    dir_d = dir;
                    cnt_d = force_cnt;
                end else begin
                    fault_d = 1'b1;
                end
            end
            ST_OUT: begin
                if (dir_q ? sns.i_pos : sns.i_neg)
                    st_d = ST_IN;
                else if (!(dir_q ? sns.v_low : sns.v_high) || expired) begin
                    st_d    = ST_IDLE;
                    fault_d = 1'b1;
                end
            end
            ST_IN: begin
                if (dir_q ? (sns.i_neg && sns.v_high) : (sns.i_pos && sns.v_low))
                    st_d = ST_ENGAGE;
                else if (expired) begin
                    st_d     = ST_IDLE;
                    parked_d = 1'b1;
                    fault_d  = 1'b1;
                end
            end
            ST_ENGAGE: begin
                st_d   = ST_IDLE;
                pos_d  = dir_q;
                done_d = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pos_hi <= 1'b1;
            parked <= 1'b0;
            dir_q  <= 1'b0;
            cnt_q  <= '0;
            done   <= 1'b0;
            fault  <= 1'b0;
        end else begin
            state  <= st_d;
            pos_hi <= pos_d;
            parked <= parked_d;
            dir_q  <= dir_d;
            cnt_q  <= cnt_d;
            done   <= done_d;
            fault  <= fault_d;
        end
    end

    always_comb begin
        gate_hi   = !parked && (((state == ST_IDLE) && pos_hi) ||
                                ((state == ST_OUT) && !dir_q) ||
                                ((state == ST_ENGAGE) && dir_q));
        gate_lo   = !parked && (((state == ST_IDLE) && !pos_hi) ||
                                ((state == ST_OUT) && dir_q) ||
                                ((state == ST_ENGAGE) && !dir_q));
        pwm_en    = (state == ST_IDLE);
        force_pos = dir_q ^ (state == ST_IN);
    end

    p_gates_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    p_pwm_off_when_forced_r3: assert property (@(posedge clk) disable iff (rst)
        (|force_mask) |-> !pwm_en);

    p_start_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OUT && $past(state) == ST_IDLE) |-> $past(dir ? sns.i_neg : sns.i_pos));

    p_zv_lower_on_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> $past(sns.v_low));

    p_zv_upper_on_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> $past(sns.v_high));

    p_parked_gates_off_r9: assert property (@(posedge clk) disable iff (rst)
        parked |-> (!gate_hi && !gate_lo));

    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));
endmodule

// File: tb/hb_soft_commutator_test.sv
module hb_soft_commutator_test;
    logic clk = 1'b0;
    logic rst, req, dir;
    logic signed [11:0] i_leg;
    logic [11:0] v_node, v_top;
    logic [2:0] force_cnt;
    logic gate_hi, gate_lo, pwm_en, force_pos, done, fault;
    logic [3:0] force_mask;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    hb_soft_commutator #(.CUR_W(12), .VOLT_W(12), .N_MOD(4), .CNT_W(3),
                         .V_TOL(10), .TMO_CYC(16)) uut (
        .clk(clk), .rst(rst), .req(req), .dir(dir), .i_leg(i_leg),
        .v_node(v_node), .v_top(v_top), .force_cnt(force_cnt),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .pwm_en(pwm_en),
        .force_mask(force_mask), .force_pos(force_pos),
        .done(done), .fault(fault)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; req = 1'b0; dir = 1'b0; i_leg = 12'sd0;
        v_node = 12'd800; v_top = 12'd800; force_cnt = 3'd0;
        step(); step();
        rst = 1'b0;
        step();
    endtask

    task automatic t_reset();
        chk("R1 gate_hi", int'(gate_hi), 1);
        chk("R1 gate_lo", int'(gate_lo), 0);
        chk("R1 pwm_en", int'(pwm_en), 1);
        chk("R1 mask", int'(force_mask), 0);
        chk("R1 flags", int'({done, fault}), 0);
    endtask

    task automatic t_down();
        i_leg = 12'sd50; v_node = 12'd800; force_cnt = 3'd2; dir = 1'b0; req = 1'b1;
        step(); req = 1'b0;
        chk("R3 pwm off", int'(pwm_en), 0);
        chk("R3 mask partial", int'(force_mask), 3);
        chk("R3 pol down", int'(force_pos), 0);
        chk("R5 outgoing held", int'(gate_hi), 1);
        dir = 1'b1; req = 1'b1;
        step(); req = 1'b0;
        chk("R10 no fault", int'(fault), 0);
        chk("R10 still sweeping", int'({gate_hi, pwm_en}), 2);
        i_leg = -12'sd5;
        step();
        chk("R5 both off", int'({gate_hi, gate_lo}), 0);
        chk("R5 pol flip", int'(force_pos), 1);
        i_leg = 12'sd5; v_node = 12'd400;
        step();
        chk("R6 wait node", int'(gate_lo), 0);
        v_node = 12'd3;
        step();
        chk("R6 lower on", int'(gate_lo), 1);
        chk("R6 pwm still off", int'(pwm_en), 0);
        chk("R2 exclusive", int'(gate_hi & gate_lo), 0);
        step();
        chk("R6 pwm back", int'(pwm_en), 1);
        chk("R6 done", int'(done), 1);
        step();
        chk("R6 done pulse", int'(done), 0);
    endtask

    task automatic t_up();
        i_leg = -12'sd50; v_node = 12'd0; force_cnt = 3'd6; dir = 1'b1; req = 1'b1;
        step(); req = 1'b0;
        chk("R3 mask saturated", int'(force_mask), 15);
        chk("R3 pol up", int'(force_pos), 1);
        chk("R5 lower held", int'(gate_lo), 1);
        i_leg = 12'sd5;
        step();
        chk("R5 up both off", int'({gate_hi, gate_lo}), 0);
        chk("R5 up pol flip", int'(force_pos), 0);
        i_leg = -12'sd5; v_node = 12'd795;
        step();
        chk("R6 upper on", int'({gate_hi, gate_lo, pwm_en}), 4);
        step();
        chk("R6 up done", int'({done, pwm_en}), 3);
    endtask

    task automatic t_reject();
        dir = 1'b1; i_leg = -12'sd20; req = 1'b1;
        step(); req = 1'b0;
        chk("R4 wrong position fault", int'(fault), 1);
        chk("R4 gates kept", int'({gate_hi, gate_lo, pwm_en}), 5);
        dir = 1'b0; i_leg = -12'sd3; req = 1'b1;
        step(); req = 1'b0;
        chk("R4 wrong sign fault", int'(fault), 1);
        chk("R4 mask idle", int'(force_mask), 0);
        step();
        chk("R4 fault pulse", int'(fault), 0);
    endtask

    task automatic t_node_abort();
        i_leg = 12'sd40; v_node = 12'd800; force_cnt = 3'd1; dir = 1'b0; req = 1'b1;
        step(); req = 1'b0;
        v_node = 12'd500;
        step();
        chk("R7 fault", int'(fault), 1);
        chk("R7 original gate", int'({gate_hi, gate_lo, pwm_en}), 5);
        v_node = 12'd800;
        step();
    endtask

    task automatic t_out_timeout();
        bit seen = 0;
        i_leg = 12'sd40; v_node = 12'd800; dir = 1'b0; req = 1'b1;
        step(); req = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            step();
            if (fault) seen = 1;
        end
        chk("R8 timeout fault", int'(seen), 1);
        chk("R8 original gate", int'({gate_hi, gate_lo, pwm_en}), 5);
    endtask

    task automatic t_in_timeout();
        bit seen = 0;
        i_leg = 12'sd40; v_node = 12'd800; dir = 1'b0; req = 1'b1;
        step(); req = 1'b0;
        i_leg = -12'sd5;
        step();
        for (int k = 0; k < 40 && !seen; k++) begin
            step();
            if (fault) seen = 1;
        end
        chk("R9 timeout fault", int'(seen), 1);
        chk("R9 parked", int'({gate_hi, gate_lo, pwm_en}), 1);
        i_leg = 12'sd40; v_node = 12'd800; dir = 1'b0; req = 1'b1;
        step(); req = 1'b0;
        chk("R9 request rejected", int'(fault), 1);
        chk("R9 still parked", int'({gate_hi, gate_lo}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_down();
        t_up();
        do_reset();
        t_reject();
        t_node_abort();
        t_out_timeout();
        t_in_timeout();
        do_reset();
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule